// File: doc/BRIEF.md
# Row-Column DFT Schedule Sequencer

This block is the control half of a programmable transform engine that computes an N-point DFT as a two-dimensional problem with N = rows × columns. After a start pulse it takes a row count and a column count, screens them, and then drives a small-DFT unit, a complex multiplier and an in-place data memory through three back-to-back passes. The first pass runs a short DFT down every column. The second pass multiplies every point by its twiddle factor. The third pass runs a short DFT along every row. On each issue cycle the sequencer supplies the memory read address, the pass identifier, the butterfly base and the short-transform length for the small-DFT unit, and the twiddle exponent for the multiplier.

Results return through a fixed-latency datapath. The sequencer replays each read address as a write address a parameterised number of cycles later. A pass does not start until every write of the pass before it has landed. Two modes exist. The mixed mode accepts sizes built only from 2, 3 and 5, for example the 72- to 1200-point single-carrier lengths. The power-of-two mode uses base 4 in both dimensions. A configuration the selected mode cannot handle raises an error flag, and the sequencer then stays idle.

Top module: `rcdft_seq`

## Requirements
- R1: After reset, busy, done, rd_en, wr_en and cfg_err are 0 and rd_phase is 3 (no pass).
- R2: A start is accepted only if both of the following hold: each dimension is non-zero and has no prime factor other than 2, 3 and 5; and rows × columns ≤ 2^ADDR_W. Otherwise cfg_err goes to 1, busy returns to 0, and no read and no done occur. An accepted start clears cfg_err.
- R3: In mixed mode (cfg_pow2 = 0), the base for a dimension of length n is the first b in the order 6, 5, 4, 3, 2 with b² dividing n. If no b qualifies, the start fails as in R2. radix_sel carries b as a binary number during column reads (rows dimension) and row reads (columns dimension), and is 0 otherwise. dft_len carries the row count during column reads, the column count during row reads, and 0 otherwise.
- R4: In power-of-two mode (cfg_pow2 = 1), both dimensions must be powers of two and multiples of 16, and radix_sel is 4 in both short-DFT passes. Any other size fails as in R2.
- R5: The column pass issues one read per cycle for N cycles with rd_phase = 0. It visits column c = 0.. in turn, with r = 0.. inside each column, at address r × cols + c.
- R6: The twiddle pass issues N reads with rd_phase = 1 in row-major order at address r × cols + c, with tw_exp = (r × c) mod N. In every other cycle, tw_exp is 0.
- R7: The row pass issues N reads with rd_phase = 2 at the contiguous addresses 0 to N−1.
- R8: Every read is followed exactly LAT cycles later by wr_en = 1 with wr_addr equal to that read's address. wr_en is 0 in all other cycles.
- R9: The first read of the twiddle pass and the first read of the row pass come LAT + 1 cycles after the last read of the previous pass, so all of that pass's writes have completed first.
- R10: done is a single-cycle pulse, one cycle after the final row-pass write. busy is 1 from the cycle after an accepted start through the done cycle.
- R11: start, cfg_rows, cfg_cols and cfg_pow2 have no effect while busy = 1. The configuration is sampled only on an accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, taken only when idle |
| cfg_rows | input | ADDR_W | Row count (column-DFT length) |
| cfg_cols | input | ADDR_W | Column count (row-DFT length) |
| cfg_pow2 | input | 1 | 1 selects power-of-two base-4 mode |
| busy | output | 1 | Transform or screening in progress |
| done | output | 1 | One-cycle completion pulse |
| cfg_err | output | 1 | Last start was rejected |
| rd_en | output | 1 | Read issue strobe |
| rd_addr | output | ADDR_W | Data-memory read address |
| rd_phase | output | 2 | 0 column, 1 twiddle, 2 row, 3 none |
| radix_sel | output | 3 | Butterfly base for the small-DFT unit |
| dft_len | output | ADDR_W | Short-DFT length for the current pass |
| tw_exp | output | ADDR_W | Twiddle exponent (r·c) mod N |
| wr_en | output | 1 | Write-back strobe |
| wr_addr | output | ADDR_W | Data-memory write address |

## Verification
The sequencer is driven with several shapes. Square and non-square sizes catch swapped row and column strides. A 36 × 25 case and a 12 × 100 case cover bases 6, 5 and 2 and the largest 1200-point length. A 4 × 9 case shows that each dimension selects its own base. Power-of-two cases separate the base-4 mode from the mixed mode, including an 8 × 8 size that is valid only in mixed mode. Rejected shapes cover a foreign prime, a dimension without a squared base, an over-large product, a zero dimension, and a non-power-of-two in base-4 mode; each of these exercises one branch of the screening. One run pokes start with a different configuration in mid-twiddle pass to show that inputs are ignored while busy.

// File: rtl/rcdft_pkg.sv
package rcdft_pkg;

   typedef enum logic [1:0] {
      PH_COL  = 2'd0,
      PH_TW   = 2'd1,
      PH_ROW  = 2'd2,
      PH_NONE = 2'd3
   } phase_e;

   typedef enum logic [2:0] {
      S_IDLE, S_CHECK, S_COL, S_TW, S_ROW, S_DRAIN, S_DONE
   } seq_state_e;

   // Butterfly base for one dimension; 0 means no legal base.
   function automatic logic [2:0] pick_base(input logic [31:0] n, input logic pow2);
      logic [2:0] b;
      b = 3'd0;
      if (n != 0) begin
         if (pow2) begin
            if ((n % 32'd16) == 0) b = 3'd4;
         end else if ((n % 32'd36) == 0) b = 3'd6;
         else if ((n % 32'd25) == 0)     b = 3'd5;
         else if ((n % 32'd16) == 0)     b = 3'd4;
         else if ((n % 32'd9)  == 0)     b = 3'd3;
         else if ((n % 32'd4)  == 0)     b = 3'd2;
      end
      return b;
   endfunction

endpackage

// File: rtl/rcdft_cfg_check.sv
module rcdft_cfg_check
   import rcdft_pkg::*;
#(
   parameter int ADDR_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] nr_i,
   input  logic [ADDR_W-1:0] nc_i,
   input  logic              pow2_i,
   output logic              settled,
   output logic              ok,
   output logic [2:0]        col_base,
   output logic [2:0]        row_base,
   output logic [ADDR_W-1:0] nr_q,
   output logic [ADDR_W-1:0] nc_q,
   output logic [ADDR_W:0]   n_total
);
   localparam int PW = 2 * ADDR_W;
   localparam int unsigned NMAX = 2 ** ADDR_W;
   localparam logic [ADDR_W-1:0] K1 = 1;
   localparam logic [ADDR_W-1:0] K2 = 2;
   localparam logic [ADDR_W-1:0] K3 = 3;
   localparam logic [ADDR_W-1:0] K5 = 5;

   logic              pow2_q;
   logic [ADDR_W-1:0] dim_q [2];
   logic [ADDR_W-1:0] rem_q [2];
   logic              can   [2];
   logic [PW-1:0]     prod;

   // One reducer per dimension strips a single small prime per cycle.
   for (genvar d = 0; d < 2; d++) begin : g_dim
      logic [ADDR_W-1:0] rem_nx;
      logic              by2, by3, by5;

      always_comb begin
         by2    = (rem_q[d] % K2) == '0;
         by3    = (rem_q[d] % K3) == '0;
         by5    = (rem_q[d] % K5) == '0;
         can[d] = (rem_q[d] != '0) && (by2 || (!pow2_q && (by3 || by5)));
         if (by2)      rem_nx = rem_q[d] >> 1;
         else if (by3) rem_nx = rem_q[d] / K3;
         else          rem_nx = rem_q[d] / K5;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            dim_q[d] <= '0;
            rem_q[d] <= '0;
         end else if (load) begin
            dim_q[d] <= (d == 0) ? nr_i : nc_i;
            rem_q[d] <= (d == 0) ? nr_i : nc_i;
         end else if (can[d]) begin
            rem_q[d] <= rem_nx;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pow2_q <= 1'b0;
      else if (load) pow2_q <= pow2_i;
   end

   assign nr_q     = dim_q[0];
   assign nc_q     = dim_q[1];
   assign prod     = {{ADDR_W{1'b0}}, dim_q[0]} * {{ADDR_W{1'b0}}, dim_q[1]};
   assign n_total  = prod[ADDR_W:0];
   assign col_base = pick_base(32'(dim_q[0]), pow2_q);
   assign row_base = pick_base(32'(dim_q[1]), pow2_q);
   assign settled  = !can[0] && !can[1];
   assign ok       = (rem_q[0] == K1) && (rem_q[1] == K1) &&
                     (col_base != 3'd0) && (row_base != 3'd0) &&
                     (prod <= PW'(NMAX));

   // R11: latched configuration moves only on an accepted start
   a_r11_cfg_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> ($stable(dim_q[0]) && $stable(dim_q[1]) && $stable(pow2_q)));

endmodule

// File: rtl/rcdft_index_gen.sv
module rcdft_index_gen #(
   parameter int ADDR_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init,
   input  logic              step,
   input  logic              col_order,
   input  logic [ADDR_W-1:0] nr,
   input  logic [ADDR_W-1:0] nc,
   input  logic [ADDR_W:0]   n_total,
   output logic [ADDR_W-1:0] addr,
   output logic [ADDR_W-1:0] tw,
   output logic              last
);
   localparam logic [ADDR_W-1:0] K1 = 1;

   logic [ADDR_W-1:0] r_q, c_q, addr_q, tw_q;
   logic              r_end, c_end;
   logic [ADDR_W:0]   tw_sum, tw_wrap;

   assign r_end   = (r_q == nr - K1);
   assign c_end   = (c_q == nc - K1);
   assign last    = r_end && c_end;
   assign tw_sum  = {1'b0, tw_q} + {1'b0, r_q};
   assign tw_wrap = (tw_sum >= n_total) ? (tw_sum - n_total) : tw_sum;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         r_q <= '0; c_q <= '0; addr_q <= '0; tw_q <= '0;
      end else if (init) begin
         r_q <= '0; c_q <= '0; addr_q <= '0; tw_q <= '0;
      end else if (step) begin
         if (col_order) begin
            // walk down a column: stride by the column count
            if (r_end) begin
               r_q    <= '0;
               c_q    <= c_q + K1;
               addr_q <= c_q + K1;
            end else begin
               r_q    <= r_q + K1;
               addr_q <= addr_q + nc;
            end
         end else begin
            // walk along a row: contiguous, exponent grows by r
            addr_q <= addr_q + K1;
            if (c_end) begin
               c_q  <= '0;
               r_q  <= r_q + K1;
               tw_q <= '0;
            end else begin
               c_q  <= c_q + K1;
               tw_q <= tw_wrap[ADDR_W-1:0];
            end
         end
      end
   end

   assign addr = addr_q;
   assign tw   = tw_q;

   // R5/R7: issued addresses stay inside the transform
   a_r5_addr_range : assert property (@(posedge clk) disable iff (!rst_n)
      step |-> ({1'b0, addr_q} < n_total));
   // R6: exponent is already reduced modulo N
   a_r6_tw_range : assert property (@(posedge clk) disable iff (!rst_n)
      step |-> ({1'b0, tw_q} < n_total));

endmodule

// File: rtl/rcdft_wr_pipe.sv
module rcdft_wr_pipe #(
   parameter int ADDR_W = 11,
   parameter int LAT    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              en_o,
   output logic [ADDR_W-1:0] addr_o
);
   logic              en_s [LAT+1];
   logic [ADDR_W-1:0] ad_s [LAT+1];

   assign en_s[0] = en_i;
   assign ad_s[0] = addr_i;

   for (genvar i = 0; i < LAT; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            en_s[i+1] <= 1'b0;
            ad_s[i+1] <= '0;
         end else begin
            en_s[i+1] <= en_s[i];
            ad_s[i+1] <= en_s[i] ? ad_s[i] : '0;
         end
      end
   end

   assign en_o   = en_s[LAT];
   assign addr_o = ad_s[LAT];

endmodule

// File: rtl/rcdft_seq.sv
module rcdft_seq
   import rcdft_pkg::*;
#(
   parameter int ADDR_W = 11,
   parameter int LAT    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] cfg_rows,
   input  logic [ADDR_W-1:0] cfg_cols,
   input  logic              cfg_pow2,
   output logic              busy,
   output logic              done,
   output logic              cfg_err,
   output logic              rd_en,
   output logic [ADDR_W-1:0] rd_addr,
   output logic [1:0]        rd_phase,
   output logic [2:0]        radix_sel,
   output logic [ADDR_W-1:0] dft_len,
   output logic [ADDR_W-1:0] tw_exp,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr
);
   localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;

   if (LAT < 1 || ADDR_W < 4) begin : g_bad_param
      $error("rcdft_seq: LAT must be >= 1 and ADDR_W >= 4");
   end

   seq_state_e        state;
   phase_e            cur_ph, from_ph;
   logic [CW-1:0]     drain_cnt;
   logic              load, settled, ok, last;
   logic [2:0]        col_base, row_base;
   logic [ADDR_W-1:0] nr_q, nc_q, idx_addr, idx_tw;
   logic [ADDR_W:0]   n_total;

   assign load = start && (state == S_IDLE);

   rcdft_cfg_check #(.ADDR_W(ADDR_W)) u_check (
      .clk(clk), .rst_n(rst_n), .load(load),
      .nr_i(cfg_rows), .nc_i(cfg_cols), .pow2_i(cfg_pow2),
      .settled(settled), .ok(ok), .col_base(col_base), .row_base(row_base),
      .nr_q(nr_q), .nc_q(nc_q), .n_total(n_total)
   );

   always_comb begin
      unique case (state)
         S_COL:   cur_ph = PH_COL;
         S_TW:    cur_ph = PH_TW;
         S_ROW:   cur_ph = PH_ROW;
         default: cur_ph = PH_NONE;
      endcase
   end

   assign rd_en = (cur_ph != PH_NONE);

   rcdft_index_gen #(.ADDR_W(ADDR_W)) u_index (
      .clk(clk), .rst_n(rst_n), .init(!rd_en), .step(rd_en),
      .col_order(state == S_COL), .nr(nr_q), .nc(nc_q), .n_total(n_total),
      .addr(idx_addr), .tw(idx_tw), .last(last)
   );

   rcdft_wr_pipe #(.ADDR_W(ADDR_W), .LAT(LAT)) u_wr (
      .clk(clk), .rst_n(rst_n), .en_i(rd_en), .addr_i(rd_addr),
      .en_o(wr_en), .addr_o(wr_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= S_IDLE;
         from_ph   <= PH_COL;
         drain_cnt <= '0;
         cfg_err   <= 1'b0;
      end else begin
         unique case (state)
            S_IDLE: if (start) begin
               state   <= S_CHECK;
               cfg_err <= 1'b0;
            end
            S_CHECK: if (settled) begin
               if (ok) state <= S_COL;
               else begin
                  state   <= S_IDLE;
                  cfg_err <= 1'b1;
               end
            end
            S_COL, S_TW, S_ROW: if (last) begin
               state     <= S_DRAIN;
               drain_cnt <= CW'(LAT - 1);
               from_ph   <= cur_ph;
            end
            S_DRAIN: begin
               if (drain_cnt == '0) begin
                  unique case (from_ph)
                     PH_COL:  state <= S_TW;
                     PH_TW:   state <= S_ROW;
                     default: state <= S_DONE;
                  endcase
               end else begin
                  drain_cnt <= drain_cnt - 1'b1;
               end
            end
            S_DONE:  state <= S_IDLE;
            default: state <= S_IDLE;
         endcase
      end
   end

   assign busy      = (state != S_IDLE);
   assign done      = (state == S_DONE);
   assign rd_phase  = cur_ph;
   assign rd_addr   = rd_en ? idx_addr : '0;
   assign tw_exp    = (state == S_TW) ? idx_tw : '0;
   assign radix_sel = (state == S_COL) ? col_base : (state == S_ROW) ? row_base : 3'd0;
   assign dft_len   = (state == S_COL) ? nr_q : (state == S_ROW) ? nc_q : '0;

   // R10: completion is a single-cycle pulse
   a_r10_done_pulse : assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R2: a rejected configuration never completes
   a_r2_no_done_on_err : assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !cfg_err);
   // R9: back-to-back reads never cross a pass boundary
   a_r9_no_phase_switch : assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && $past(rd_en)) |-> (rd_phase == $past(rd_phase)));
   // R8: writes only drain after reads have been issued
   a_r8_wr_in_run : assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> busy);

endmodule

// File: tb/tb_rcdft_seq.sv
module tb_rcdft_seq;
   localparam int ADDR_W = 11;
   localparam int LAT    = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [ADDR_W-1:0] cfg_rows = '0;
   logic [ADDR_W-1:0] cfg_cols = '0;
   logic              cfg_pow2 = 1'b0;
   logic              busy, done, cfg_err, rd_en, wr_en;
   logic [ADDR_W-1:0] rd_addr, dft_len, tw_exp, wr_addr;
   logic [1:0]        rd_phase;
   logic [2:0]        radix_sel;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   rcdft_seq #(.ADDR_W(ADDR_W), .LAT(LAT)) dut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .cfg_rows(cfg_rows), .cfg_cols(cfg_cols), .cfg_pow2(cfg_pow2),
      .busy(busy), .done(done), .cfg_err(cfg_err),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_phase(rd_phase),
      .radix_sel(radix_sel), .dft_len(dft_len), .tw_exp(tw_exp),
      .wr_en(wr_en), .wr_addr(wr_addr)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int exp_addr(input int ph, input int k, input int nr, input int nc);
      if (ph == 0) return (k % nr) * nc + (k / nr);
      return k;
   endfunction

   task automatic t_reset();
      chk("R1", "busy after reset", int'(busy), 0);
      chk("R1", "done after reset", int'(done), 0);
      chk("R1", "rd_en after reset", int'(rd_en), 0);
      chk("R1", "wr_en after reset", int'(wr_en), 0);
      chk("R1", "cfg_err after reset", int'(cfg_err), 0);
      chk("R1", "rd_phase after reset", int'(rd_phase), 3);
   endtask

   task automatic kick(input int nr, input int nc, input bit p2);
      @(negedge clk);
      cfg_rows = ADDR_W'(nr); cfg_cols = ADDR_W'(nc); cfg_pow2 = p2;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   // Full transform against the index model; poke pulses start mid-run (R11).
   task automatic t_run(input int nr, input int nc, input bit p2,
                        input int cb, input int rb, input bit poke);
      int n, waited;
      n = nr * nc;
      waited = 0;
      kick(nr, nc, p2);
      chk("R2", "cfg_err cleared by accepted start", int'(cfg_err), 0);
      while (!rd_en && waited < 40) begin
         if (!busy) break;
         @(negedge clk);
         waited++;
      end
      chk("R2", "valid config starts the column pass", int'(rd_en), 1);
      if (!rd_en) return;
      for (int ph = 0; ph < 3; ph++) begin
         int bad_rd = 0, bad_wr = 0, bad_gap = 0;
         int a_rd = 0, e_rd = 0, a_wr = 0, e_wr = 0, a_gp = 0;
         for (int j = 0; j < n + LAT; j++) begin
            if (j < n) begin
               int ea, et, er, el, r, c;
               ea = exp_addr(ph, j, nr, nc);
               r = j / nc; c = j % nc;
               et = (ph == 1) ? (r * c) % n : 0;
               er = (ph == 0) ? cb : (ph == 2) ? rb : 0;
               el = (ph == 0) ? nr : (ph == 2) ? nc : 0;
               if (!rd_en || int'(rd_addr) != ea || int'(rd_phase) != ph ||
                   int'(tw_exp) != et || int'(radix_sel) != er || int'(dft_len) != el) begin
                  if (bad_rd == 0) begin a_rd = int'(rd_addr); e_rd = ea; end
                  bad_rd++;
               end
            end else if (rd_en || int'(rd_phase) != 3 || tw_exp != '0) begin
               if (bad_gap == 0) a_gp = int'(rd_phase);
               bad_gap++;
            end
            if (j >= LAT) begin
               int ew;
               ew = exp_addr(ph, j - LAT, nr, nc);
               if (!wr_en || int'(wr_addr) != ew) begin
                  if (bad_wr == 0) begin a_wr = int'(wr_addr); e_wr = ew; end
                  bad_wr++;
               end
            end else if (wr_en) begin
               if (bad_wr == 0) begin a_wr = 1; e_wr = 0; end
               bad_wr++;
            end
            if (!busy || done) bad_gap++;
            start = (poke && ph == 1 && j == 3);
            if (start) begin
               cfg_rows = 7; cfg_cols = 3; cfg_pow2 = ~p2;
            end
            @(negedge clk);
         end
         case (ph)
            0: chk("R5 R3 R4", "column pass read stream, first bad addr", a_rd, e_rd);
            1: chk("R6 R11", "twiddle pass read stream, first bad addr", a_rd, e_rd);
            default: chk("R7 R3 R4", "row pass read stream, first bad addr", a_rd, e_rd);
         endcase
         chk("R5 R6 R7", "mismatched read cycles in pass", bad_rd, 0);
         chk("R8", "write stream, first bad wr_addr", a_wr, e_wr);
         chk("R8", "mismatched write cycles in pass", bad_wr, 0);
         chk("R9", "drain gap cycles with reads or idle", bad_gap, 0);
         if (bad_gap != 0) chk("R9", "phase seen in drain gap", a_gp, 3);
      end
      chk("R10", "done one cycle after last write", int'(done), 1);
      chk("R10", "busy during done cycle", int'(busy), 1);
      @(negedge clk);
      chk("R10", "done lasts one cycle", int'(done), 0);
      chk("R10", "busy falls after done", int'(busy), 0);
   endtask

   task automatic t_bad(input int nr, input int nc, input bit p2, input string req);
      int waited;
      bit saw_rd, saw_done;
      waited = 0; saw_rd = 0; saw_done = 0;
      kick(nr, nc, p2);
      while (busy && waited < 40) begin
         saw_rd |= rd_en;
         saw_done |= done;
         @(negedge clk);
         waited++;
      end
      chk(req, "busy returns to idle on reject", int'(busy), 0);
      chk(req, "cfg_err on reject", int'(cfg_err), 1);
      chk(req, "no read on reject", int'(saw_rd), 0);
      chk(req, "no done on reject", int'(saw_done), 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_run(4, 4, 1'b0, 2, 2, 1'b0);      // smallest mixed shape
      t_run(4, 9, 1'b0, 2, 3, 1'b0);      // per-dimension base, non-square (R3)
      t_bad(14, 4, 1'b0, "R2");           // prime 7
      t_run(36, 25, 1'b0, 6, 5, 1'b0);    // bases 6 and 5 (R3)
      t_bad(36, 2, 1'b0, "R3");           // no squared base
      t_run(8, 8, 1'b0, 2, 2, 1'b0);      // legal only in mixed mode (R3)
      t_bad(8, 8, 1'b1, "R4");            // too short for base 4
      t_run(16, 32, 1'b1, 4, 4, 1'b0);    // base-4 mode (R4)
      t_bad(12, 12, 1'b1, "R4");          // not a power of two
      t_bad(64, 64, 1'b0, "R2");          // product beyond address space
      t_bad(0, 4, 1'b0, "R2");            // zero dimension
      t_run(12, 100, 1'b0, 2, 5, 1'b1);   // 1200 points, start poked (R11)
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule